// File: doc/BRIEF.md
# Ones-Density Calibration Meter

The meter runs one calibration measurement on a 1-bit sigma-delta modulator stream. A start strobe begins a sequence. The meter first holds the modulator in reset for a short, fixed number of cycles. It then raises one of two selects toward the modulator front end. In offset mode it raises the select that grounds the modulator inputs. In gain mode it raises the select that applies the reference to the inputs. While that select is high, the meter waits a fixed settling time and then counts the ones in a window of 2^N stream bits.

When the window closes, the meter subtracts the ideal ones count for the selected calibration and input range from the measured count. It latches that signed error word and pulses done for one cycle. The stream delivers one bit per clock.

The result is flagged as usable only while the input range mode stays the same as the one captured at start. A range change during the measurement, or any later change, withdraws that flag. A start strobe is accepted only while the meter is idle. Applying the error word to filtered data is left to the consumer.

Top module: `caldens_meter`

## Requirements
- R1: While rst_n is low and after its release, mod_rst_o, zero_sel_o, gain_sel_o, busy_o, done_o and res_ok_o are 0 and err_o is 0.
- R2: A start_i sampled high while idle raises busy_o and mod_rst_o on the following cycle. mod_rst_o stays high for exactly RST_CYC cycles, with both selects low.
- R3: After the reset phase, exactly one select is high for SETTLE_CYC + 2^WIN_LOG2 cycles. zero_sel_o is the select when cal_gain_i was 0 at start, and gain_sel_o is the select when it was 1. The two selects are never high together.
- R4: Only the stream bits sampled during the last 2^WIN_LOG2 cycles of the select phase are counted. Bits seen during the reset and settling phases have no effect on err_o.
- R5: The ideal count is 5·2^(WIN_LOG2-3) in gain mode, whatever the range. In offset mode it is 2^(WIN_LOG2-1) when range_bip_i is 1 (bipolar) and 3·2^(WIN_LOG2-3) when range_bip_i is 0 (unipolar).
- R6: err_o is the two's-complement value (ones counted − ideal count), WIN_LOG2+2 bits wide. It is loaded in the cycle done_o is high and holds its value in every other cycle.
- R7: done_o is high for exactly one cycle, the cycle after the last counted bit is sampled, and busy_o falls in that same cycle.
- R8: start_i is ignored while busy_o is high; it does not restart or lengthen the sequence.
- R9: res_ok_o rises with done_o only if range_bip_i equalled its start value on every clock of the measurement. It falls on the clock after range_bip_i differs from that value, and stays low until the next done_o.
- R10: cal_gain_i and range_bip_i are sampled only at an accepted start. Later changes to cal_gain_i do not alter the select or the ideal count of the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock, one stream bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe for one measurement |
| cal_gain_i | input | 1 | 1 selects gain calibration, 0 offset calibration |
| range_bip_i | input | 1 | 1 selects bipolar range, 0 unipolar |
| stream_i | input | 1 | Modulator bit stream |
| mod_rst_o | output | 1 | Holds the modulator in reset |
| zero_sel_o | output | 1 | Grounds the modulator inputs (offset measurement) |
| gain_sel_o | output | 1 | Applies the reference to the inputs (gain measurement) |
| busy_o | output | 1 | A measurement is in progress |
| done_o | output | 1 | One-cycle pulse when err_o is loaded |
| err_o | output | WIN_LOG2+2 | Signed count error, measured minus ideal |
| res_ok_o | output | 1 | err_o belongs to the present range mode |

## Verification
The hardest cases are a range change that happens inside a measurement and is undone before the window closes, and stream bits that arrive during settling. Neither shows up in err_o or res_ok_o until long after the stimulus. The bench toggles range_bip_i away from its start value and back in the middle of a measurement, and the reference must then predict a cleared flag at done. It also drives ones only through the reset and settling phases and zeros through the window, so any early counting appears as a wrong error word. Strobes of start_i and flips of cal_gain_i inside busy periods test that the sampled settings stay fixed.

// File: rtl/cdm_pkg.sv
package cdm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_RST    = 2'd1,
    PH_SETTLE = 2'd2,
    PH_COUNT  = 2'd3
  } phase_e;
endpackage

// File: rtl/cdm_seq.sv
module cdm_seq
  import cdm_pkg::*;
#(
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 1000,
  parameter int WIN_LOG2   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cal_gain_i,
  output logic accept_o,
  output logic count_en_o,
  output logic last_o,
  output logic gain_q_o,
  output logic mod_rst_o,
  output logic zero_sel_o,
  output logic gain_sel_o,
  output logic busy_o
);
  localparam int WIN  = 1 << WIN_LOG2;
  localparam int M1   = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int MAXC = (M1 > WIN) ? M1 : WIN;
  localparam int CW   = $clog2(MAXC) + 1;

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          gain_q, gain_d;
  logic          cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept_o = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    gain_d = gain_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d   = PH_RST;
          cnt_d  = CW'(RST_CYC - 1);
          gain_d = cal_gain_i;
        end
      end
      PH_RST: begin
        if (cnt_zero) begin
          ph_d  = PH_SETTLE;
          cnt_d = CW'(SETTLE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_SETTLE: begin
        if (cnt_zero) begin
          ph_d  = PH_COUNT;
          cnt_d = CW'(WIN - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_COUNT: begin
        if (cnt_zero) ph_d = PH_IDLE;
        else          cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      gain_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      gain_q <= gain_d;
    end
  end

  assign count_en_o = (ph_q == PH_COUNT);
  assign last_o     = count_en_o && cnt_zero;
  assign gain_q_o   = gain_q;
  assign busy_o     = (ph_q != PH_IDLE);
  assign mod_rst_o  = (ph_q == PH_RST);
  assign zero_sel_o = ((ph_q == PH_SETTLE) || count_en_o) && !gain_q;
  assign gain_sel_o = ((ph_q == PH_SETTLE) || count_en_o) && gain_q;

  assert_sel_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_sel_o && gain_sel_o));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ph_q != PH_COUNT) |=> busy_o && !$rose(mod_rst_o));
  assert_mode_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(gain_q));
endmodule

// File: rtl/cdm_tally.sv
module cdm_tally #(
  parameter int WIN_LOG2 = 8,
  parameter int RES_W    = WIN_LOG2 + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear_i,
  input  logic                    count_en_i,
  input  logic                    last_i,
  input  logic                    bit_i,
  input  logic                    gain_i,
  input  logic                    bip_i,
  output logic signed [RES_W-1:0] err_o,
  output logic                    done_o
);
  localparam int WIN = 1 << WIN_LOG2;
  localparam logic [RES_W-1:0] IDEAL_HALF  = RES_W'(WIN / 2);
  localparam logic [RES_W-1:0] IDEAL_3_8   = RES_W'((WIN / 8) * 3);
  localparam logic [RES_W-1:0] IDEAL_5_8   = RES_W'((WIN / 8) * 5);

  logic [WIN_LOG2:0] ones_q, ones_d;
  logic [RES_W-1:0]  ideal;
  logic [RES_W-1:0]  err_q, err_d;
  logic              done_q, done_d;

  always_comb begin
    if (gain_i)     ideal = IDEAL_5_8;
    else if (bip_i) ideal = IDEAL_HALF;
    else            ideal = IDEAL_3_8;
  end

  always_comb begin
    ones_d = ones_q;
    err_d  = err_q;
    done_d = last_i;
    if (clear_i)         ones_d = '0;
    else if (count_en_i) ones_d = ones_q + {{WIN_LOG2{1'b0}}, bit_i};
    if (last_i)
      err_d = RES_W'(ones_q) + RES_W'(bit_i) - ideal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
      err_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ones_q <= ones_d;
      err_q  <= err_d;
      done_q <= done_d;
    end
  end

  assign err_o  = $signed(err_q);
  assign done_o = done_q;

  assert_ones_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= (WIN_LOG2+1)'(WIN));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(err_q)));
endmodule

// File: rtl/cdm_guard.sv
module cdm_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic busy_i,
  input  logic last_i,
  input  logic range_i,
  output logic bip_q_o,
  output logic ok_o
);
  logic bip_q, bip_d;
  logic moved_q, moved_d;
  logic ok_q, ok_d;
  logic same;

  assign same = (range_i == bip_q);

  always_comb begin
    bip_d   = bip_q;
    moved_d = moved_q;
    if (last_i) ok_d = !moved_q && same;
    else        ok_d = ok_q && same;
    if (accept_i) begin
      bip_d   = range_i;
      moved_d = 1'b0;
    end else if (busy_i && !same) begin
      moved_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bip_q   <= 1'b0;
      moved_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      bip_q   <= bip_d;
      moved_q <= moved_d;
      ok_q    <= ok_d;
    end
  end

  assign bip_q_o = bip_q;
  assign ok_o    = ok_q;

  assert_ok_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (range_i != bip_q) |=> !ok_o);
  assert_ok_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_o) |-> $past(last_i));
endmodule

// File: rtl/caldens_meter.sv
module caldens_meter #(
  parameter int RST_CYC    = 4,
  parameter int SETTLE_CYC = 1000,
  parameter int WIN_LOG2   = 8,
  localparam int RES_W     = WIN_LOG2 + 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    cal_gain_i,
  input  logic                    range_bip_i,
  input  logic                    stream_i,
  output logic                    mod_rst_o,
  output logic                    zero_sel_o,
  output logic                    gain_sel_o,
  output logic                    busy_o,
  output logic                    done_o,
  output logic signed [RES_W-1:0] err_o,
  output logic                    res_ok_o
);
  logic accept, count_en, last, gain_q, bip_q;

  cdm_seq #(
    .RST_CYC    (RST_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .WIN_LOG2   (WIN_LOG2)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .cal_gain_i (cal_gain_i),
    .accept_o   (accept),
    .count_en_o (count_en),
    .last_o     (last),
    .gain_q_o   (gain_q),
    .mod_rst_o  (mod_rst_o),
    .zero_sel_o (zero_sel_o),
    .gain_sel_o (gain_sel_o),
    .busy_o     (busy_o)
  );

  cdm_tally #(
    .WIN_LOG2 (WIN_LOG2),
    .RES_W    (RES_W)
  ) tally_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept),
    .count_en_i (count_en),
    .last_i     (last),
    .bit_i      (stream_i),
    .gain_i     (gain_q),
    .bip_i      (bip_q),
    .err_o      (err_o),
    .done_o     (done_o)
  );

  cdm_guard guard_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (accept),
    .busy_i   (busy_o),
    .last_i   (last),
    .range_i  (range_bip_i),
    .bip_q_o  (bip_q),
    .ok_o     (res_ok_o)
  );

  assert_done_after_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(zero_sel_o || gain_sel_o));
  assert_reset_no_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mod_rst_o |-> !(zero_sel_o || gain_sel_o));
endmodule

// File: tb/caldens_meter_tb_top.sv
module caldens_meter_tb_top;
  localparam int RST  = 4;
  localparam int SET  = 1000;
  localparam int LG   = 8;
  localparam int WIN  = 1 << LG;
  localparam int RW   = LG + 2;

  logic clk = 1'b0;
  logic rst_n, start_i, cal_gain_i, range_bip_i, stream_i;
  logic mod_rst_o, zero_sel_o, gain_sel_o, busy_o, done_o, res_ok_o;
  logic signed [RW-1:0] err_o;

  int vectors = 0;
  int fails   = 0;
  int cyc     = 0;
  int pat     = 0;

  // reference state
  int m_busy, m_t, m_gain, m_bip, m_ones, m_done, m_res, m_ok, m_moved;

  always #2 clk = ~clk;

  caldens_meter #(.RST_CYC(RST), .SETTLE_CYC(SET), .WIN_LOG2(LG)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_gain_i(cal_gain_i),
    .range_bip_i(range_bip_i), .stream_i(stream_i), .mod_rst_o(mod_rst_o),
    .zero_sel_o(zero_sel_o), .gain_sel_o(gain_sel_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .res_ok_o(res_ok_o)
  );

  function automatic int ideal_of(int g, int b);
    if (g != 0)      return (WIN * 5) / 8;
    else if (b != 0) return WIN / 2;
    else             return (WIN * 3) / 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_t = 0; m_gain = 0; m_bip = 0; m_ones = 0;
      m_done = 0; m_res = 0; m_ok = 0; m_moved = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0 && m_t == RST + SET + WIN) m_ok = (m_moved == 0 && range_bip_i == m_bip);
      else m_ok = m_ok & (range_bip_i == m_bip);
      if (m_busy != 0 && range_bip_i != m_bip) m_moved = 1;
      if (m_busy == 0) begin
        if (start_i) begin
          m_busy = 1; m_t = 1; m_gain = cal_gain_i; m_bip = range_bip_i;
          m_ones = 0; m_moved = 0;
        end
      end else begin
        if (m_t >= RST + SET + 1) m_ones += stream_i;
        if (m_t == RST + SET + WIN) begin
          m_busy = 0; m_done = 1; m_res = m_ones - ideal_of(m_gain, m_bip);
        end else m_t++;
      end
    end
  end

  // compare every cycle, then drive the next stream bit
  always @(negedge clk) begin
    if (rst_n) begin
      int e_rst, e_sel;
      e_rst = (m_busy != 0 && m_t <= RST);
      e_sel = (m_busy != 0 && m_t > RST);
      chk(mod_rst_o == e_rst, "R2 mod_rst", mod_rst_o, e_rst);
      chk(zero_sel_o == (e_sel && m_gain == 0), "R3 zero_sel", zero_sel_o, e_sel && m_gain == 0);
      chk(gain_sel_o == (e_sel && m_gain != 0), "R3 gain_sel", gain_sel_o, e_sel && m_gain != 0);
      chk(busy_o == m_busy, "R8 busy", busy_o, m_busy);
      chk(done_o == m_done, "R7 done", done_o, m_done);
      chk(int'(err_o) == m_res, "R6 err", int'(err_o), m_res);
      chk(res_ok_o == m_ok, "R9 res_ok", res_ok_o, m_ok);
    end
    case (pat)
      1: stream_i <= 1'b1;
      2: stream_i <= 1'($urandom % 2);
      3: stream_i <= (m_busy != 0 && m_t <= RST + SET);
      default: stream_i <= 1'b0;
    endcase
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic launch(input bit g, input bit b, input int p);
    @(negedge clk);
    cal_gain_i = g; range_bip_i = b; pat = p; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done;
    while (done_o !== 1'b1) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; cal_gain_i = 1'b0; range_bip_i = 1'b1;
    stream_i = 1'b0;
    repeat (3) @(negedge clk);
    chk({mod_rst_o, zero_sel_o, gain_sel_o, busy_o, done_o, res_ok_o} == 6'b0,
        "R1 outputs in reset", {mod_rst_o, zero_sel_o, gain_sel_o, busy_o, done_o, res_ok_o}, 0);
    chk(err_o == '0, "R1 err in reset", int'(err_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // offset, unipolar, all ones: WIN - 3/8 WIN
    launch(1'b0, 1'b0, 1); wait_done;
    chk(int'(err_o) == WIN - (WIN * 3) / 8, "R5 offset unipolar ideal", int'(err_o), WIN - (WIN * 3) / 8);
    chk(res_ok_o == 1'b1, "R9 ok after clean run", res_ok_o, 1);

    // offset, bipolar, ones only before the window
    launch(1'b0, 1'b1, 3); wait_done;
    chk(int'(err_o) == -(WIN / 2), "R4 settle bits not counted", int'(err_o), -(WIN / 2));

    // gain, unipolar and bipolar, zeros: ideal independent of range
    launch(1'b1, 1'b0, 0); wait_done;
    chk(int'(err_o) == -((WIN * 5) / 8), "R5 gain unipolar", int'(err_o), -((WIN * 5) / 8));
    launch(1'b1, 1'b1, 0); wait_done;
    chk(int'(err_o) == -((WIN * 5) / 8), "R5 gain bipolar", int'(err_o), -((WIN * 5) / 8));

    // random streams
    launch(1'b0, 1'b1, 2); wait_done;
    launch(1'b1, 1'b0, 2); wait_done;

    // start strobes and mode flips while busy
    launch(1'b0, 1'b1, 1);
    repeat (20) @(negedge clk);
    start_i = 1'b1; cal_gain_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (1100) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done;
    chk(int'(err_o) == WIN / 2, "R10 mode held, R8 restart ignored", int'(err_o), WIN / 2);
    cal_gain_i = 1'b0;

    // range change after done drops the flag
    repeat (3) @(negedge clk);
    range_bip_i = 1'b0;
    repeat (2) @(negedge clk);
    chk(res_ok_o == 1'b0, "R9 flag drops on range change", res_ok_o, 0);

    // range flips and returns inside a measurement
    launch(1'b0, 1'b1, 2);
    repeat (600) @(negedge clk);
    range_bip_i = 1'b0;
    @(negedge clk);
    range_bip_i = 1'b1;
    wait_done;
    chk(res_ok_o == 1'b0, "R9 flag stays low after mid-run change", res_ok_o, 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule